// File: doc/BRIEF.md
# Write protection command sequencer

This block sits between a host's byte-write strobe and the page loader of a byte-wide nonvolatile memory. It watches every host write (address plus data) for short keyed command strings. The strings switch a software write-protection flag on or off, unlock a single page write while protection is on, and request an erase of the whole array to all-ones. Every other write goes to the page loader only when the flag allows it. Key bytes themselves never reach the loader.

The key strings are built from three command addresses and a small set of command bytes. Only address bits 14..0 take part in the match. Each key byte must follow the previous write within a programmable gap of `LOAD_TIMEOUT` clock cycles, or the partial string is dropped. After the three-byte unlock string, a load window opens. Writes that arrive within the gap limit of each other are then forwarded whatever the flag says. When the window expires, protection is on. A soft reset clears the matcher and any open window but keeps the flag, which models its non-volatility. Only the power-on reset returns the flag to the unprotected state.

Top module: `wp_cmd_seq`

## Requirements
- R1: While `por_n` is low, and on its release, `prot_on`, `fwd_valid` and `erase_req` are 0.
- R2: While unprotected, a write that is not part of a key is forwarded: `fwd_valid` is 1 in the cycle after the write, with `fwd_addr`/`fwd_data` equal to the written address and data.
- R3: The unlock string is 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. After it, writes are forwarded. `prot_on` becomes 1 exactly `LOAD_TIMEOUT` cycles after the last write of the window, and stays 0 one cycle earlier.
- R4: While protected and outside a window, ordinary writes are not forwarded.
- R5: While protected, the unlock string opens a window in which writes are forwarded. Protection is still on after the window closes, and later writes are blocked.
- R6: The string 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 clears `prot_on` in the cycle after its last write.
- R7: The same string ending in 0x10@0x5555 pulses `erase_req` for one cycle after its last write when unprotected. When protected, it gives no pulse.
- R8: A write accepted as a key byte is never forwarded.
- R9: A write that does not match the next expected key byte returns the matcher to idle and is handled as an ordinary write (forwarded only if unprotected).
- R10: A key byte is accepted up to `LOAD_TIMEOUT` cycles after the previous write, that is, after at most `LOAD_TIMEOUT-1` idle cycles. After one more idle cycle, the partial key is dropped and the next byte is ordinary.
- R11: Address bits 16 and 15 are ignored when matching key addresses.
- R12: A soft reset (`rst_n` low) leaves `prot_on` unchanged and drops any partial key and any open window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears the flag |
| rst_n | input | 1 | Synchronous soft reset, active low; keeps the flag |
| wr_valid | input | 1 | Host byte-write strobe, one cycle per byte |
| wr_addr | input | 17 | Host write address |
| wr_data | input | 8 | Host write data |
| fwd_valid | output | 1 | Write forwarded to the page loader |
| fwd_addr | output | 17 | Forwarded address |
| fwd_data | output | 8 | Forwarded data |
| erase_req | output | 1 | One-cycle whole-array erase request |
| prot_on | output | 1 | Software write-protection flag |

## Verification
The hardest situation to reach is the exact edge of the gap limit. A key byte or a window write sent after `LOAD_TIMEOUT-1` idle cycles must still count, and one cycle later it must not. A whole six-byte erase string is sent with the maximum legal gap between every byte. A second string is then broken by a gap one cycle longer, and the stray byte is seen to be forwarded as plain data. The moment protection rises after an unlock window is sampled in both neighbouring cycles. A soft reset is applied between the second and third unlock bytes, so that a window that would have opened shows up as a blocked write.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] KEY_LEAD   = 8'hAA;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_OPEN   = 8'hA0;
    localparam logic [BYTE_W-1:0] KEY_EXT    = 8'h80;
    localparam logic [BYTE_W-1:0] KEY_UNPROT = 8'h20;
    localparam logic [BYTE_W-1:0] KEY_ERASE  = 8'h10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_K3,
        ST_K4,
        ST_K5,
        ST_OPEN
    } seq_state_e;

    typedef enum logic [2:0] {
        TK_NONE,
        TK_LEAD_HI,
        TK_SECOND_LO,
        TK_OPEN_HI,
        TK_EXT_HI,
        TK_UNPROT_HI,
        TK_ERASE_HI
    } key_tok_e;

endpackage

// File: rtl/wp_key_decode.sv
module wp_key_decode
    import wp_seq_pkg::*;
#(
    parameter int KEY_AW = 15,
    parameter logic [KEY_AW-1:0] ADDR_HI = 'h5555,
    parameter logic [KEY_AW-1:0] ADDR_LO = 'h2AAA
) (
    input  logic [KEY_AW-1:0] key_addr,
    input  logic [BYTE_W-1:0] key_data,
    output key_tok_e          tok
);

    always_comb begin
        tok = TK_NONE;
        if (key_addr == ADDR_HI) begin
            case (key_data)
                KEY_LEAD:   tok = TK_LEAD_HI;
                KEY_OPEN:   tok = TK_OPEN_HI;
                KEY_EXT:    tok = TK_EXT_HI;
                KEY_UNPROT: tok = TK_UNPROT_HI;
                KEY_ERASE:  tok = TK_ERASE_HI;
                default:    tok = TK_NONE;
            endcase
        end else if (key_addr == ADDR_LO && key_data == KEY_SECOND) begin
            tok = TK_SECOND_LO;
        end
    end

endmodule

// File: rtl/wp_gap_timer.sv
module wp_gap_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic clr,
    input  logic run,
    input  logic restart,
    output logic expire
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || restart || !run) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + CW'(1);
        end
        expire = run && !restart && !clr && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
    import wp_seq_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int KEY_AW       = 15,
    parameter int LOAD_TIMEOUT = 16,
    parameter logic [KEY_AW-1:0] ADDR_HI = 'h5555,
    parameter logic [KEY_AW-1:0] ADDR_LO = 'h2AAA
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [BYTE_W-1:0] fwd_data,
    output logic              erase_req,
    output logic              prot_on
);

    typedef struct packed {
        seq_state_e        state;
        logic              prot;
        logic              fwd_valid;
        logic [ADDR_W-1:0] fwd_addr;
        logic [BYTE_W-1:0] fwd_data;
        logic              erase;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state:     ST_IDLE,
        prot:      1'b0,
        fwd_valid: 1'b0,
        fwd_addr:  '0,
        fwd_data:  '0,
        erase:     1'b0
    };

    regs_t    r_d, r_q;
    key_tok_e tok;
    logic     expire;
    logic     ordinary;
    logic     win_open;

    assign win_open = (r_q.state == ST_OPEN);

    wp_key_decode #(
        .KEY_AW  (KEY_AW),
        .ADDR_HI (ADDR_HI),
        .ADDR_LO (ADDR_LO)
    ) i_decode (
        .key_addr (wr_addr[KEY_AW-1:0]),
        .key_data (wr_data),
        .tok      (tok)
    );

    wp_gap_timer #(
        .LIMIT (LOAD_TIMEOUT)
    ) i_gap (
        .clk     (clk),
        .por_n   (por_n),
        .clr     (!rst_n),
        .run     (r_q.state != ST_IDLE),
        .restart (wr_valid),
        .expire  (expire)
    );

    always_comb begin
        r_d           = r_q;
        r_d.fwd_valid = 1'b0;
        r_d.erase     = 1'b0;
        ordinary      = 1'b0;
        if (wr_valid) begin
            r_d.fwd_addr = wr_addr;
            r_d.fwd_data = wr_data;
        end
        if (!rst_n) begin
            r_d.state = ST_IDLE;
        end else if (wr_valid) begin
            case (r_q.state)
                ST_IDLE: begin
                    if (tok == TK_LEAD_HI) r_d.state = ST_K1;
                    else                   ordinary  = 1'b1;
                end
                ST_K1: begin
                    if (tok == TK_SECOND_LO) begin
                        r_d.state = ST_K2;
                    end else begin
                        r_d.state = ST_IDLE;
                        ordinary  = 1'b1;
                    end
                end
                ST_K2: begin
                    if (tok == TK_OPEN_HI) begin
                        r_d.state = ST_OPEN;
                    end else if (tok == TK_EXT_HI) begin
                        r_d.state = ST_K3;
                    end else begin
                        r_d.state = ST_IDLE;
                        ordinary  = 1'b1;
                    end
                end
                ST_K3: begin
                    if (tok == TK_LEAD_HI) begin
                        r_d.state = ST_K4;
                    end else begin
                        r_d.state = ST_IDLE;
                        ordinary  = 1'b1;
                    end
                end
                ST_K4: begin
                    if (tok == TK_SECOND_LO) begin
                        r_d.state = ST_K5;
                    end else begin
                        r_d.state = ST_IDLE;
                        ordinary  = 1'b1;
                    end
                end
                ST_K5: begin
                    r_d.state = ST_IDLE;
                    if (tok == TK_UNPROT_HI) begin
                        r_d.prot = 1'b0;
                    end else if (tok == TK_ERASE_HI) begin
                        r_d.erase = !r_q.prot;
                    end else begin
                        ordinary = 1'b1;
                    end
                end
                ST_OPEN: begin
                    r_d.fwd_valid = 1'b1;
                end
                default: begin
                    r_d.state = ST_IDLE;
                end
            endcase
            if (ordinary) begin
                r_d.fwd_valid = !r_q.prot;
            end
        end else if (expire) begin
            if (r_q.state == ST_OPEN) begin
                r_d.prot = 1'b1;
            end
            r_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign fwd_valid = r_q.fwd_valid;
    assign fwd_addr  = r_q.fwd_addr;
    assign fwd_data  = r_q.fwd_data;
    assign erase_req = r_q.erase;
    assign prot_on   = r_q.prot;

endmodule

// File: rtl/wp_cmd_seq_chk.sv
module wp_cmd_seq_chk (
    input logic clk,
    input logic por_n,
    input logic rst_n,
    input logic wr_valid,
    input logic win_open,
    input logic fwd_valid,
    input logic erase_req,
    input logic prot_on
);

    a_r1_por_clears: assert property (@(posedge clk)
        !por_n |=> (!prot_on && !fwd_valid && !erase_req))
        else $error("R1: outputs not cleared by power-on reset");

    a_r4_blocked_when_protected: assert property (@(posedge clk) disable iff (!por_n)
        fwd_valid |-> ($past(win_open) || !$past(prot_on)))
        else $error("R4: write forwarded while protected");

    a_r7_erase_only_unprotected: assert property (@(posedge clk) disable iff (!por_n)
        erase_req |-> !prot_on)
        else $error("R7: erase requested while protected");

    a_r7_erase_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
        erase_req |=> !erase_req)
        else $error("R7: erase request longer than one cycle");

    a_r3_prot_rises_from_window: assert property (@(posedge clk) disable iff (!por_n)
        $rose(prot_on) |-> $past(win_open))
        else $error("R3: protection set outside an expiring window");

    a_r6_prot_falls_on_write: assert property (@(posedge clk) disable iff (!por_n)
        $fell(prot_on) |-> ($past(wr_valid) && $past(rst_n)))
        else $error("R6: protection cleared without a host write");

    a_r12_soft_reset_keeps_flag: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> $stable(prot_on))
        else $error("R12: soft reset changed the protection flag");

    a_r8_fwd_erase_exclusive: assert property (@(posedge clk) disable iff (!por_n)
        !(fwd_valid && erase_req))
        else $error("R8: erase key byte forwarded");

endmodule

bind wp_cmd_seq wp_cmd_seq_chk i_wp_cmd_seq_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .win_open  (win_open),
    .fwd_valid (fwd_valid),
    .erase_req (erase_req),
    .prot_on   (prot_on)
);

// File: tb/test_wp_cmd_seq.sv
`timescale 1ns/1ps
module test_wp_cmd_seq;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b1;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        fwd_valid;
    logic [16:0] fwd_addr;
    logic [7:0]  fwd_data;
    logic        erase_req;
    logic        prot_on;

    int checks = 0;
    int errors = 0;
    int s_fwd, s_addr, s_data, s_erase, s_prot;

    always #5 clk = ~clk;

    wp_cmd_seq #(.LOAD_TIMEOUT(TMO)) i_wp_cmd_seq (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_data(fwd_data),
        .erase_req(erase_req), .prot_on(prot_on)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // starts and ends at a falling edge; samples the registered result
    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
        s_fwd   = int'(fwd_valid);
        s_addr  = int'(fwd_addr);
        s_data  = int'(fwd_data);
        s_erase = int'(erase_req);
        s_prot  = int'(prot_on);
    endtask

    task automatic key(input logic [16:0] a, input logic [7:0] d);
        wr(a, d);
        chk("R8", "key byte forwarded", s_fwd, 0);
    endtask

    task automatic t_reset;
        por_n = 1'b0;
        idle(3);
        chk("R1", "prot in reset", int'(prot_on), 0);
        por_n = 1'b1;
        idle(1);
        chk("R1", "prot after reset", int'(prot_on), 0);
        chk("R1", "fwd after reset", int'(fwd_valid), 0);
        chk("R1", "erase after reset", int'(erase_req), 0);
    endtask

    task automatic t_plain;
        wr(17'h1_0123, 8'h5A);
        chk("R2", "fwd valid", s_fwd, 1);
        chk("R2", "fwd addr", s_addr, 'h1_0123);
        chk("R2", "fwd data", s_data, 'h5A);
        idle(1);
        chk("R2", "fwd single cycle", int'(fwd_valid), 0);
    endtask

    task automatic t_erase_open;
        key(17'h5555, 8'hAA); key(17'h2AAA, 8'h55); key(17'h5555, 8'h80);
        key(17'h5555, 8'hAA); key(17'h2AAA, 8'h55); key(17'h5555, 8'h10);
        chk("R7", "erase pulse unprotected", s_erase, 1);
        idle(1);
        chk("R7", "erase pulse width", int'(erase_req), 0);
        chk("R7", "prot unchanged by erase", int'(prot_on), 0);
    endtask

    task automatic t_gap;
        key(17'h5555, 8'hAA); idle(TMO-1);
        key(17'h2AAA, 8'h55); idle(TMO-1);
        key(17'h5555, 8'h80); idle(TMO-1);
        key(17'h5555, 8'hAA); idle(TMO-1);
        key(17'h2AAA, 8'h55); idle(TMO-1);
        key(17'h5555, 8'h10);
        chk("R10", "erase at max gap", s_erase, 1);
        key(17'h5555, 8'hAA); idle(TMO);
        wr(17'h2AAA, 8'h55);
        chk("R10", "byte after expiry is ordinary", s_fwd, 1);
        chk("R10", "ordinary data", s_data, 'h55);
    endtask

    task automatic t_mismatch_open;
        key(17'h5555, 8'hAA);
        wr(17'h2AAA, 8'h56);
        chk("R9", "mismatch forwarded unprotected", s_fwd, 1);
        chk("R9", "mismatch data", s_data, 'h56);
        wr(17'h2AAA, 8'h55);
        chk("R9", "matcher back in idle", s_fwd, 1);
    endtask

    task automatic t_enable;
        key(17'h5555, 8'hAA); key(17'h2AAA, 8'h55); key(17'h5555, 8'hA0);
        wr(17'h00400, 8'h11);
        chk("R3", "window write 1", s_fwd, 1);
        wr(17'h00401, 8'h22);
        chk("R3", "window write 2", s_fwd, 1);
        chk("R3", "window write 2 addr", s_addr, 'h401);
        idle(TMO-1);
        chk("R3", "prot before expiry", int'(prot_on), 0);
        idle(1);
        chk("R3", "prot at expiry", int'(prot_on), 1);
    endtask

    task automatic t_prot_write;
        wr(17'h00500, 8'h33);
        chk("R4", "protected write blocked", s_fwd, 0);
        chk("R4", "prot held", s_prot, 1);
    endtask

    task automatic t_prot_erase;
        key(17'h5555, 8'hAA); key(17'h2AAA, 8'h55); key(17'h5555, 8'h80);
        key(17'h5555, 8'hAA); key(17'h2AAA, 8'h55); key(17'h5555, 8'h10);
        chk("R7", "no erase when protected", s_erase, 0);
        chk("R7", "prot after blocked erase", s_prot, 1);
    endtask

    task automatic t_unlock;
        key(17'h5555, 8'hAA); key(17'h2AAA, 8'h55); key(17'h5555, 8'hA0);
        wr(17'h00600, 8'h44);
        chk("R5", "unlocked write forwarded", s_fwd, 1);
        chk("R5", "unlocked data", s_data, 'h44);
        idle(TMO);
        chk("R5", "prot stays on", int'(prot_on), 1);
        wr(17'h00601, 8'h55);
        chk("R5", "write after window blocked", s_fwd, 0);
    endtask

    task automatic t_mismatch_prot;
        key(17'h5555, 8'hAA);
        wr(17'h2AAA, 8'h57);
        chk("R9", "mismatch blocked protected", s_fwd, 0);
    endtask

    task automatic t_soft;
        key(17'h5555, 8'hAA); key(17'h2AAA, 8'h55);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        chk("R12", "prot kept over soft reset", int'(prot_on), 1);
        wr(17'h5555, 8'hA0);
        chk("R12", "stale key byte blocked", s_fwd, 0);
        wr(17'h00700, 8'h66);
        chk("R12", "no window after soft reset", s_fwd, 0);
    endtask

    task automatic t_disable;
        key(17'h5555, 8'hAA); key(17'h2AAA, 8'h55); key(17'h5555, 8'h80);
        key(17'h5555, 8'hAA); key(17'h2AAA, 8'h55); key(17'h5555, 8'h20);
        chk("R6", "prot cleared", s_prot, 0);
        wr(17'h00800, 8'h77);
        chk("R6", "write after disable", s_fwd, 1);
    endtask

    task automatic t_highbits;
        key(17'h1_D555, 8'hAA); key(17'h1_2AAA, 8'h55); key(17'h0_D555, 8'hA0);
        wr(17'h00900, 8'h88);
        chk("R11", "window via high-bit addresses", s_fwd, 1);
        idle(TMO);
        chk("R11", "prot set via high-bit key", int'(prot_on), 1);
        key(17'h1_5555, 8'hAA); key(17'h0_AAAA, 8'h55); key(17'h1_D555, 8'h80);
        key(17'h0_D555, 8'hAA); key(17'h1_AAAA, 8'h55); key(17'h1_5555, 8'h20);
        chk("R11", "disable via high-bit key", s_prot, 0);
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        chk("R12", "unprotected kept over soft reset", int'(prot_on), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_plain();
        t_erase_open();
        t_gap();
        t_mismatch_open();
        t_enable();
        t_prot_write();
        t_prot_erase();
        t_unlock();
        t_mismatch_prot();
        t_soft();
        t_disable();
        t_highbits();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule